// File: doc/BRIEF.md
# Bank-Switched Fixed-Memory Address Mapper

This block turns a 12-bit instruction address into a physical location in a woven-wire read-only memory. The upper quarter pair of the address space is wired to two fixed banks. One 1K window follows a 5-bit bank register. The lowest quarter belongs to read/write memory and is only flagged. A separate extension bit stretches the 32 switchable banks to 40: it raises banks 24 to 31 by eight and leaves banks 0 to 23 as they are. That bit arrives as one bit of an I/O channel word.

The physical bank number is converted into rope, module, strand and core indices. Each module holds six consecutive 1K banks as twelve 512-core strands. Two modules make up one rope. Only three ropes exist, so the four highest physical banks land on an unimplemented location and are flagged. Software changes banks through a small register-write port. All mapped outputs are registered with one cycle of latency.

Top module: `rom_bank_mapper`

## Requirements
- R1: When addr[11:10] is 00, the next output cycle shows erasable=1, unimpl=0 and physBank, rope, modSel, strand and core all zero.
- R2: When addr[11:10] is 10, the physical bank is 2. When it is 11, the physical bank is 3. Neither depends on the bank register or the extension bit.
- R3: When addr[11:10] is 01, the physical bank comes from the bank register.
- R4: With the bank register at 0 to 23, the windowed physical bank equals the register value whether the extension bit is 0 or 1.
- R5: With the bank register at 24 to 31, the windowed physical bank is the register value plus 8 when the extension bit is 1, and the register value when it is 0 (for example, 26 becomes 34).
- R6: A write with wrEn=1 and wrSel=0 loads the bank register from wrData[4:0]. A write with wrSel=1 loads the extension bit from wrData[4], and wrData[3:0] have no effect. A write is seen by a lookup launched in the cycle after the write edge; a lookup launched at the write edge itself still uses the old value.
- R7: For a mapped address with physical bank b, let m = b/6. Then rope = m/2, modSel = m mod 2, strand = 2*(b mod 6) + addr[9], and core = addr[8:0].
- R8: unimpl=1 exactly when a mapped location has rope 3 or strand 12 to 15. This happens for physical banks 36 to 39.
- R9: Outputs are registered. A lookup presented before a clock edge appears after that edge. While rstN is low, all outputs are zero and the bank register and extension bit clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Instruction address to map |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0: bank register, 1: channel word carrying the extension bit |
| wrData | input | 5 | Write data |
| erasable | output | 1 | Address lies in read/write memory |
| unimpl | output | 1 | Mapped location is not implemented |
| physBank | output | 6 | Physical bank number 0..39 |
| rope | output | 2 | Rope index |
| modSel | output | 1 | Module within the rope |
| strand | output | 4 | Strand within the module |
| core | output | 9 | Core within the strand |

## Verification
The bench walks the four address regions with the bank register both below and above 24, and with the extension bit set and cleared. This separates hard-wired banks from windowed ones and shows the bit acting only on the top eight banks. Banks 23, 24, 31, 34 and 35 sit on the edges of the extension range and of the implemented ropes, which is where the unimplemented flag must turn on. A write issued in the same cycle as a lookup separates old-value from new-value timing. Seeded random addresses, writes and channel words then compare every location field against a model of the division into ropes, modules and strands.

// File: rtl/rom_bank_pkg.sv
package rom_bank_pkg;
  localparam int ADDR_W        = 12;
  localparam int REGION_W      = 2;
  localparam int OFFSET_W      = ADDR_W - REGION_W;
  localparam int CORE_W        = 9;
  localparam int STRAND_W      = 4;
  localparam int ROPE_W        = 2;
  localparam int BANK_W        = 5;
  localparam int PBANK_W       = 6;
  localparam int DATA_W        = BANK_W;
  localparam int EXT_BIT       = DATA_W - 1;
  localparam int BANKS_PER_MOD = 6;
  localparam int MODS_PER_ROPE = 2;
  localparam int STRANDS_IMPL  = 12;
  localparam int ROPES_IMPL    = 3;
  localparam int EXT_BASE      = 24;
  localparam int EXT_ADD       = 8;

  typedef enum logic [REGION_W-1:0] {
    RG_ERASE  = 2'b00,
    RG_WINDOW = 2'b01,
    RG_FIXA   = 2'b10,
    RG_FIXB   = 2'b11
  } region_e;

  typedef struct packed {
    logic loadBank;
    logic loadExt;
    logic isErasable;
    logic useWindow;
  } ctrl_t;
endpackage

// File: rtl/rom_bank_ctrl.sv
module rom_bank_ctrl
  import rom_bank_pkg::*;
(
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [REGION_W-1:0] region,
  output ctrl_t               ctrl
);
  region_e regionKind;

  always_comb begin
    regionKind      = region_e'(region);
    ctrl.loadBank   = wrEn && !wrSel;
    ctrl.loadExt    = wrEn && wrSel;
    ctrl.isErasable = (regionKind == RG_ERASE);
    ctrl.useWindow  = (regionKind == RG_WINDOW);
  end
endmodule

// File: rtl/rom_bank_datapath.sv
module rom_bank_datapath
  import rom_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [BANK_W-1:0]   bankQ,
  output logic                extQ,
  output logic                erasable,
  output logic                unimpl,
  output logic [PBANK_W-1:0]  physBank,
  output logic [ROPE_W-1:0]   rope,
  output logic                modSel,
  output logic [STRAND_W-1:0] strand,
  output logic [CORE_W-1:0]   core
);
  logic [PBANK_W-1:0]  bankSel;
  logic [PBANK_W-1:0]  modIdx;
  logic [PBANK_W-1:0]  bankInMod;
  logic [ROPE_W-1:0]   ropeN;
  logic                modN;
  logic [STRAND_W-1:0] strandN;
  logic [CORE_W-1:0]   coreN;
  logic                unimplN;
  logic [OFFSET_W-1:0] offset;

  // bank register and extension bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= '0;
      extQ  <= 1'b0;
    end else begin
      if (ctrl.loadBank) bankQ <= wrData[BANK_W-1:0];
      if (ctrl.loadExt)  extQ  <= wrData[EXT_BIT];
    end
  end

  // bank selection and physical split
  always_comb begin
    offset = addr[OFFSET_W-1:0];
    if (ctrl.useWindow) begin
      if (extQ && (bankQ >= BANK_W'(EXT_BASE)))
        bankSel = PBANK_W'(bankQ) + PBANK_W'(EXT_ADD);
      else
        bankSel = PBANK_W'(bankQ);
    end else begin
      bankSel = PBANK_W'(addr[ADDR_W-1:OFFSET_W]);
    end
    modIdx    = bankSel / PBANK_W'(BANKS_PER_MOD);
    bankInMod = bankSel % PBANK_W'(BANKS_PER_MOD);
    ropeN     = ROPE_W'(modIdx / PBANK_W'(MODS_PER_ROPE));
    modN      = modIdx[0];
    strandN   = (STRAND_W'(bankInMod) << 1) | STRAND_W'(offset[CORE_W]);
    coreN     = offset[CORE_W-1:0];
    unimplN   = (strandN >= STRAND_W'(STRANDS_IMPL)) ||
                (ropeN >= ROPE_W'(ROPES_IMPL));
  end

  // registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      erasable <= 1'b0;
      unimpl   <= 1'b0;
      physBank <= '0;
      rope     <= '0;
      modSel   <= 1'b0;
      strand   <= '0;
      core     <= '0;
    end else if (ctrl.isErasable) begin
      erasable <= 1'b1;
      unimpl   <= 1'b0;
      physBank <= '0;
      rope     <= '0;
      modSel   <= 1'b0;
      strand   <= '0;
      core     <= '0;
    end else begin
      erasable <= 1'b0;
      unimpl   <= unimplN;
      physBank <= bankSel;
      rope     <= ropeN;
      modSel   <= modN;
      strand   <= strandN;
      core     <= coreN;
    end
  end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rom_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [DATA_W-1:0]   wrData,
  output logic                erasable,
  output logic                unimpl,
  output logic [PBANK_W-1:0]  physBank,
  output logic [ROPE_W-1:0]   rope,
  output logic                modSel,
  output logic [STRAND_W-1:0] strand,
  output logic [CORE_W-1:0]   core
);
  ctrl_t             ctrl;
  logic [BANK_W-1:0] bankQ;
  logic              extQ;

  rom_bank_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .region (addr[ADDR_W-1:OFFSET_W]),
    .ctrl   (ctrl)
  );

  rom_bank_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .addr     (addr),
    .wrData   (wrData),
    .bankQ    (bankQ),
    .extQ     (extQ),
    .erasable (erasable),
    .unimpl   (unimpl),
    .physBank (physBank),
    .rope     (rope),
    .modSel   (modSel),
    .strand   (strand),
    .core     (core)
  );
endmodule

// File: rtl/rom_bank_mapper_chk.sv
module rom_bank_mapper_chk
  import rom_bank_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   addr,
  input logic [BANK_W-1:0]   bankQ,
  input logic                extQ,
  input logic                erasable,
  input logic                unimpl,
  input logic [PBANK_W-1:0]  physBank,
  input logic [STRAND_W-1:0] strand
);
  // R1
  a_r1_erasable_flag: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1:OFFSET_W] == 2'b00) |=> (erasable && !unimpl && physBank == '0));

  // R2
  a_r2_hard_bank: assert property (@(posedge clk) disable iff (!rstN)
    addr[ADDR_W-1] |=> (!erasable && physBank == PBANK_W'($past(addr[ADDR_W-1:OFFSET_W]))));

  // R4
  a_r4_low_bank: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1:OFFSET_W] == 2'b01 && bankQ < BANK_W'(EXT_BASE))
      |=> (physBank == {1'b0, $past(bankQ)}));

  // R5
  a_r5_ext_add: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1:OFFSET_W] == 2'b01 && bankQ >= BANK_W'(EXT_BASE) && extQ)
      |=> (physBank == {1'b0, $past(bankQ)} + PBANK_W'(EXT_ADD)));

  // R8
  a_r8_top_banks_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (!erasable && physBank >= PBANK_W'(36)) |-> unimpl);

  // R8
  a_r8_strand_range: assert property (@(posedge clk) disable iff (!rstN)
    (!unimpl) |-> (strand < STRAND_W'(STRANDS_IMPL)));
endmodule

bind rom_bank_mapper rom_bank_mapper_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .bankQ    (bankQ),
  .extQ     (extQ),
  .erasable (erasable),
  .unimpl   (unimpl),
  .physBank (physBank),
  .strand   (strand)
);

// File: tb/rom_bank_mapper_tb.sv
`timescale 1ns/1ps
module rom_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [4:0]  wrData = '0;
  logic        erasable, unimpl, modSel;
  logic [5:0]  physBank;
  logic [1:0]  rope;
  logic [3:0]  strand;
  logic [8:0]  core;

  int checks = 0;
  int errors = 0;
  logic [4:0] mBank = '0;
  logic       mExt = 1'b0;
  logic [23:0] oldExp;

  always #2 clk = ~clk;

  rom_bank_mapper u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .erasable(erasable), .unimpl(unimpl),
    .physBank(physBank), .rope(rope), .modSel(modSel),
    .strand(strand), .core(core)
  );

  function automatic logic [23:0] expMap(logic [11:0] a, logic [4:0] b, logic s);
    int bank, m, bim;
    logic [1:0] rp;
    logic [3:0] st;
    if (a[11:10] == 2'b00) return {1'b1, 23'd0};
    if (a[11:10] == 2'b01) bank = (b >= 24 && s) ? int'(b) + 8 : int'(b);
    else bank = int'(a[11:10]);
    m   = bank / 6;
    bim = bank % 6;
    rp  = 2'(m / 2);
    st  = 4'(bim * 2 + int'(a[9]));
    return {1'b0, (rp == 2'd3 || st >= 4'd12), 6'(bank), rp, 1'(m % 2), st, a[8:0]};
  endfunction

  task automatic checkOut(string req, logic [23:0] exp);
    logic [23:0] got;
    got = {erasable, unimpl, physBank, rope, modSel, strand, core};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic lookup(string req, logic [11:0] a);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    checkOut(req, expMap(a, mBank, mExt));
  endtask

  task automatic writeReg(logic sel, logic [4:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel) mExt = d[4]; else mBank = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20181030));
    addr = 12'h7FF;
    repeat (3) @(negedge clk);
    checkOut("R9 reset outputs zero", 24'h0);
    rstN = 1'b1;

    // R1 read/write region
    lookup("R1 erasable low", 12'h000);
    lookup("R1 erasable high", 12'h3FF);
    // R9 reset state of bank register: window maps to bank 0
    lookup("R9 reset bank zero", 12'h400);
    // R2 hard-wired banks ignore register and extension bit
    writeReg(1'b0, 5'd30);
    writeReg(1'b1, 5'h10);
    lookup("R2 fixed bank 2", 12'h8A5);
    lookup("R2 fixed bank 3", 12'hFFF);
    // R3 R7 window
    writeReg(1'b0, 5'd5);
    lookup("R3 R7 bank 5", 12'h523);
    lookup("R7 strand odd", 12'h7FF);
    // R4 below extension range
    writeReg(1'b0, 5'd23);
    lookup("R4 bank 23 ext set", 12'h400);
    // R5 extension
    writeReg(1'b0, 5'd26);
    lookup("R5 bank 26 to 34", 12'h601);
    writeReg(1'b0, 5'd24);
    lookup("R5 bank 24 to 32", 12'h400);
    writeReg(1'b0, 5'd27);
    lookup("R7 bank 35 last implemented", 12'h7FF);
    // R8 unimplemented
    writeReg(1'b0, 5'd28);
    lookup("R8 bank 36 unimpl", 12'h400);
    writeReg(1'b0, 5'd31);
    lookup("R8 bank 39 unimpl", 12'h7FF);
    // R6 channel write: low bits ignored, bit 4 clears extension
    writeReg(1'b1, 5'h0F);
    lookup("R6 R5 ext cleared bank 31", 12'h400);
    writeReg(1'b0, 5'd26);
    lookup("R5 bank 26 no ext", 12'h601);

    // R6 R9 write timing
    writeReg(1'b0, 5'd10);
    @(negedge clk);
    addr = 12'h4C0; wrEn = 1'b1; wrSel = 1'b0; wrData = 5'd12;
    oldExp = expMap(12'h4C0, 5'd10, mExt);
    @(negedge clk);
    wrEn = 1'b0;
    mBank = 5'd12;
    checkOut("R6 same-edge lookup old bank", oldExp);
    @(negedge clk);
    checkOut("R6 next lookup new bank", expMap(12'h4C0, mBank, mExt));

    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) writeReg(1'b0, 5'($urandom));
      else if (r == 1) writeReg(1'b1, 5'($urandom));
      lookup("R3 R7 R8 random", 12'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule